// File: doc/BRIEF.md
# Audio Sample-Rate Strobe Generator

This block turns a fixed master clock enable into per-channel sample-rate strobes for three audio channels: two playback channels and one capture channel. The master enable is an input strobe that pulses at 1,411,200 Hz. Every output rate is an integer division of it.

The first playback channel takes its rate from a 2-bit select. The select picks one of four power-of-two divisors of the master tick, which gives roughly 5512, 11025, 22050 and 44100 Hz. The second playback channel and the capture channel share one programmable divider. That divider has a 13-bit field, and its effective divisor is the field value plus two. Each strobe is gated by its channel's run input. A counter stays cleared while nothing that uses it is running. A new divider value is adopted only at the end of the period in progress.

Top module: `audio_rate_strobe`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all three tick outputs are low.
- R2: With `run_p1` high and `master_tick` high every cycle, `tick_p1` repeats every 2^(8-`rate_sel`) master ticks. Select 0 gives 256, 1 gives 128, 2 gives 64 and 3 gives 32.
- R3: With a playback-2 or capture run high, the shared divider emits one strobe every `div_val`+2 master ticks. `div_val` is 13 bits, so the divisors run from 2 to 8193.
- R4: `tick_p2` and `tick_cap` come from the same divider. When both channels run, their pulses coincide cycle for cycle.
- R5: A tick output goes high only in the cycle after a cycle in which that channel's run input was high. A stopped channel produces no ticks, even while the other channels tick.
- R6: A counter whose channels are all stopped is held at zero. While the shared divider is idle it follows `div_val`. After a run input rises, the first tick appears D master ticks later, where D is the channel's divisor.
- R7: A change to `div_val` while the shared divider runs does not alter the period in progress. The new value applies from the next terminal count.
- R8: Periods are counted in master ticks. A cycle with `master_tick` low does not advance any counter.
- R9: Every tick output is high for exactly one clock cycle per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_tick | input | 1 | Master rate enable, one cycle per master tick |
| rate_sel | input | 2 | Playback-1 fixed-rate select |
| div_val | input | 13 | Shared divider value (divisor = value + 2) |
| run_p1 | input | 1 | Playback channel 1 running |
| run_p2 | input | 1 | Playback channel 2 running |
| run_cap | input | 1 | Capture channel running |
| tick_p1 | output | 1 | Playback-1 sample strobe |
| tick_p2 | output | 1 | Playback-2 sample strobe |
| tick_cap | output | 1 | Capture sample strobe |

## Verification
The assertions assume that the run inputs, `rate_sel` and `div_val` are synchronous to `clk` and may change in any cycle. They also assume that `master_tick` may be high in any subset of cycles, so none of them relies on a regular master-tick pattern. The stimulus changes inputs only on falling clock edges. It sets `div_val` one cycle before raising a run input, so the idle divider has already taken the value when counting starts. `master_tick` is driven either high in every cycle or high in alternate cycles.

// File: rtl/ars_pkg.sv
package ars_pkg;

    localparam int unsigned ARS_DIV_W     = 13;
    localparam int unsigned ARS_SEL_W     = 2;
    localparam int unsigned ARS_MIN_LOG2  = 5;
    localparam int unsigned ARS_NUM_CHAN  = 3;

    // channel vector carried from raw strobes to output registers
    typedef struct packed {
        logic cap;
        logic p2;
        logic p1;
    } chan_vec_t;

    // log2 of the fixed divisor: the highest select picks the smallest divisor
    function automatic int unsigned fix_log2(input int unsigned sel,
                                             input int unsigned sel_w,
                                             input int unsigned min_log2);
        return min_log2 + ((32'd1 << sel_w) - 32'd1) - sel;
    endfunction

endpackage

// File: rtl/ars_fixed_gen.sv
module ars_fixed_gen #(
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned MIN_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_tick,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             term
);
    import ars_pkg::*;

    localparam int unsigned PRE_W = MIN_LOG2 + (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] tap_mask;
    int unsigned      tap_lg;

    always_comb begin
        tap_lg = fix_log2(32'(sel), SEL_W, MIN_LOG2);
        for (int i = 0; i < int'(PRE_W); i++) begin
            tap_mask[i] = (i < int'(tap_lg));
        end
    end

    assign term = master_tick & run & ((pre_cnt & tap_mask) == tap_mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
        end else if (master_tick) begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    p_fix_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_cnt == '0));

    p_fix_step_r8: assert property (@(posedge clk) disable iff (rst)
        (run && !master_tick) |=> $stable(pre_cnt));

endmodule

// File: rtl/ars_shared_div.sv
module ars_shared_div #(
    parameter int unsigned DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_tick,
    input  logic             run_any,
    input  logic [DIV_W-1:0] div_val,
    output logic             term
);
    localparam int unsigned CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] act_div;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             hit;

    // divisor is value + 2, so the count runs 0 .. value + 1
    assign last = CNT_W'(act_div) + CNT_W'(1);
    assign hit  = (cnt == last);
    assign term = master_tick & run_any & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_div <= '0;
        end else if (!run_any) begin
            cnt     <= '0;
            act_div <= div_val;
        end else if (master_tick) begin
            if (hit) begin
                cnt     <= '0;
                act_div <= div_val;
            end else begin
                cnt     <= cnt + CNT_W'(1);
            end
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);

    p_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !run_any |=> (cnt == '0));

    p_reload_at_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(act_div));

    p_div_step_r8: assert property (@(posedge clk) disable iff (rst)
        (run_any && !master_tick) |=> $stable(cnt));

endmodule

// File: rtl/ars_tick_reg.sv
module ars_tick_reg #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] run,
    output logic [N-1:0] tick
);
    for (genvar i = 0; i < int'(N); i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                tick[i] <= 1'b0;
            end else begin
                tick[i] <= raw[i] & run[i];
            end
        end

        p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
            tick[i] |=> !tick[i]);

        p_run_gate_r5: assert property (@(posedge clk) disable iff (rst)
            tick[i] |-> $past(run[i]));
    end

endmodule

// File: rtl/audio_rate_strobe.sv
module audio_rate_strobe
    import ars_pkg::*;
#(
    parameter int unsigned DIV_W    = ARS_DIV_W,
    parameter int unsigned SEL_W    = ARS_SEL_W,
    parameter int unsigned MIN_LOG2 = ARS_MIN_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_tick,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             run_p1,
    input  logic             run_p2,
    input  logic             run_cap,
    output logic             tick_p1,
    output logic             tick_p2,
    output logic             tick_cap
);
    localparam int unsigned NCH = ARS_NUM_CHAN;

    chan_vec_t raw_v;
    chan_vec_t run_v;
    chan_vec_t tick_v;
    logic      raw_fix;
    logic      raw_sh;
    logic      run_sh;

    assign run_sh = run_p2 | run_cap;

    ars_fixed_gen #(
        .SEL_W    (SEL_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_fix (
        .clk         (clk),
        .rst         (rst),
        .master_tick (master_tick),
        .run         (run_p1),
        .sel         (rate_sel),
        .term        (raw_fix)
    );

    ars_shared_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk         (clk),
        .rst         (rst),
        .master_tick (master_tick),
        .run_any     (run_sh),
        .div_val     (div_val),
        .term        (raw_sh)
    );

    always_comb begin
        raw_v.p1  = raw_fix;
        raw_v.p2  = raw_sh;
        raw_v.cap = raw_sh;
        run_v.p1  = run_p1;
        run_v.p2  = run_p2;
        run_v.cap = run_cap;
    end

    ars_tick_reg #(
        .N (NCH)
    ) u_out (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_v),
        .run  (run_v),
        .tick (tick_v)
    );

    assign tick_p1  = tick_v.p1;
    assign tick_p2  = tick_v.p2;
    assign tick_cap = tick_v.cap;

    p_shared_coincide_r4: assert property (@(posedge clk) disable iff (rst)
        (run_p2 && run_cap) |=> (tick_p2 == tick_cap));

endmodule

// File: tb/sim_audio_rate_strobe.sv
module sim_audio_rate_strobe;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_tick = 1'b0;
    logic        mt_alt = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic [12:0] div_val = 13'd0;
    logic        run_p1 = 1'b0;
    logic        run_p2 = 1'b0;
    logic        run_cap = 1'b0;
    logic        tick_p1, tick_p2, tick_cap;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    audio_rate_strobe u0 (
        .clk(clk), .rst(rst), .master_tick(master_tick),
        .rate_sel(rate_sel), .div_val(div_val),
        .run_p1(run_p1), .run_p2(run_p2), .run_cap(run_cap),
        .tick_p1(tick_p1), .tick_p2(tick_p2), .tick_cap(tick_cap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // master tick: every cycle, or every other cycle
    initial begin
        forever begin
            @(negedge clk);
            master_tick = mt_alt ? ~master_tick : 1'b1;
        end
    end

    function automatic logic pick(input int w);
        case (w)
            0: return tick_p1;
            1: return tick_p2;
            default: return tick_cap;
        endcase
    endfunction

    task automatic check(input int actual, input int expected, input string tag);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic do_reset();
        run_p1 = 0; run_p2 = 0; run_cap = 0; mt_alt = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic measure_gap(input int w, output int gap);
        gap = -1;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (pick(w)) break;
        end
        for (int j = 1; j < 20000; j++) begin
            @(negedge clk);
            if (pick(w)) begin gap = j; break; end
        end
    endtask

    task automatic count_pulses(input int w, input int cycles, output int cnt);
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pick(w)) cnt++;
        end
    endtask

    task automatic t_reset();
        rst = 1;
        run_p1 = 1; run_p2 = 1; run_cap = 1;
        repeat (3) @(negedge clk);
        check(tick_p1, 0, "R1 p1 in reset");
        check(tick_p2, 0, "R1 p2 in reset");
        check(tick_cap, 0, "R1 cap in reset");
        run_p1 = 0; run_p2 = 0; run_cap = 0;
        rst = 0;
        @(negedge clk);
        check(tick_p1 | tick_p2 | tick_cap, 0, "R1 after reset");
    endtask

    task automatic t_fixed_rates();
        int g;
        for (int s = 0; s < 4; s++) begin
            do_reset();
            rate_sel = 2'(s);
            run_p1 = 1;
            measure_gap(0, g);
            check(g, 32 << (3 - s), "R2 p1 period");
        end
    endtask

    task automatic t_shared_rates();
        int g;
        int vals[3] = '{0, 5, 8191};
        foreach (vals[i]) begin
            do_reset();
            div_val = 13'(vals[i]);
            @(negedge clk);
            run_p2 = 1;
            measure_gap(1, g);
            check(g, vals[i] + 2, "R3 shared period");
        end
    endtask

    task automatic t_both_shared();
        int mism = 0;
        int pulses = 0;
        do_reset();
        div_val = 13'd3;
        @(negedge clk);
        run_p2 = 1; run_cap = 1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (tick_p2 != tick_cap) mism++;
            if (tick_cap) pulses++;
        end
        check(mism, 0, "R4 p2/cap coincide");
        check(pulses, 10, "R4 cap pulses in 50 cycles");
    endtask

    task automatic t_gating();
        int c2, c1, cc;
        do_reset();
        div_val = 13'd2;
        @(negedge clk);
        run_cap = 1;
        fork
            count_pulses(1, 60, c2);
            count_pulses(0, 60, c1);
            count_pulses(2, 60, cc);
        join
        check(c2, 0, "R5 stopped p2 silent");
        check(c1, 0, "R5 stopped p1 silent");
        check(cc, 15, "R5 running cap pulses");
    endtask

    task automatic t_start_latency();
        int first;
        do_reset();
        div_val = 13'd9;
        repeat (3) @(negedge clk);
        run_cap = 1;
        first = -1;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (tick_cap) begin first = k; break; end
        end
        check(first, 11, "R6 shared first tick latency");
        do_reset();
        rate_sel = 2'd3;
        repeat (5) @(negedge clk);
        run_p1 = 1;
        first = -1;
        for (int k = 1; k < 100; k++) begin
            @(negedge clk);
            if (tick_p1) begin first = k; break; end
        end
        check(first, 32, "R6 p1 first tick latency");
    endtask

    task automatic t_reload();
        int g1, g2;
        do_reset();
        div_val = 13'd4;
        @(negedge clk);
        run_cap = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tick_cap) break;
        end
        div_val = 13'd10;
        g1 = -1;
        for (int j = 1; j < 100; j++) begin
            @(negedge clk);
            if (tick_cap) begin g1 = j; break; end
        end
        g2 = -1;
        for (int j = 1; j < 100; j++) begin
            @(negedge clk);
            if (tick_cap) begin g2 = j; break; end
        end
        check(g1, 6, "R7 period in progress keeps old divisor");
        check(g2, 12, "R7 new divisor after terminal count");
    endtask

    task automatic t_sparse_master();
        int g;
        do_reset();
        mt_alt = 1;
        div_val = 13'd3;
        @(negedge clk);
        run_p2 = 1;
        measure_gap(1, g);
        check(g, 10, "R8 shared period with master every other cycle");
        run_p2 = 0;
        rate_sel = 2'd3;
        run_p1 = 1;
        measure_gap(0, g);
        check(g, 64, "R8 p1 period with master every other cycle");
        mt_alt = 0;
    endtask

    task automatic t_width();
        int pulses = 0;
        int back2back = 0;
        logic prev = 0;
        do_reset();
        div_val = 13'd0;
        @(negedge clk);
        run_p2 = 1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (tick_p2) pulses++;
            if (tick_p2 && prev) back2back++;
            prev = tick_p2;
        end
        check(back2back, 0, "R9 no two-cycle pulse");
        check(pulses, 20, "R9 pulse count at divisor 2");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fixed_rates();
        t_shared_rates();
        t_both_shared();
        t_gating();
        t_start_latency();
        t_reload();
        t_sparse_master();
        t_width();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule